// File: doc/BRIEF.md
# Set/Clear Interrupt Flag Controller

This block is the interrupt unit of a small peripheral. It holds seven pending flags and seven enable bits. It drives one level-sensitive interrupt line that stays high while any pending flag is also enabled. The timers, the serial shifter and the handshake logic sit outside the block. Each one reports an event as a one-cycle pulse on its own bit of `evt_set`, and that pulse makes the matching flag pending.

Software reaches the block over a byte-wide register bus with a 4-bit select. The flag and enable registers can both be read. A write to the enable register uses bit 7 to choose between two actions: with bit 7 set, the written 1 bits are added to the mask; with bit 7 clear, they are removed. A write to the flag register clears each flag whose data bit is 1.

The block also watches bus accesses to the timer and shifter registers of its neighbours. Certain of those accesses clear the matching flag as a side effect, so a handler that services the event does not need a separate acknowledge. The block owns the address decode for these side-effect clears.

Top module: `irq_flag_ctrl`

## Requirements
- R1: `irq` is a register. It is 1 in the cycle after an edge where the stored flags AND the stored enables were nonzero, and 0 otherwise.
- R2: While `reg_sel` is 0xD (flag register), `rd_data[6:0]` shows the stored flags. `rd_data[7]` is 1 exactly when some flag is both set and enabled.
- R3: While `reg_sel` is 0xE (enable register), `rd_data[6:0]` shows the enable mask and `rd_data[7]` reads 1.
- R4: A write to 0xE with data bit 7 = 1 ORs data bits 6:0 into the mask. A write with data bit 7 = 0 clears each mask bit where the data holds a 1. Mask bits with a data 0 are kept in both cases.
- R5: A write to 0xD clears each flag whose data bit (6:0) is 1. Flags with a data 0 are unchanged, and data bit 7 is ignored.
- R6: Flag bit 6 (timer 1) clears on a read of 0x4, a write of 0x5 or a write of 0x7.
- R7: Flag bit 5 (timer 2) clears on a read of 0x8 or a write of 0x9.
- R8: Flag bit 2 (shifter) clears on a read of 0xA.
- R9: After reset, all flags and all enable bits are 0 and `irq` is 0.
- R10: A 1 on `evt_set[i]` sets flag i on the next edge, even if a clear of flag i happens in the same cycle.
- R11: No flag changes on any other access. This includes a write of 0x4, a read of 0x5, a read of 0x9, a write of 0xA, and reads of 0xD or 0xE. For every other `reg_sel` value, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 4 | Register select on the bus |
| rd_en | input | 1 | Read strobe for the selected register |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register (combinational) |
| evt_set | input | 7 | One-cycle event pulses, one per flag |
| irq | output | 1 | Registered interrupt request level |

## Verification
An event pulse and a clearing access can land on the same flag in the same cycle. The clearing access may be a flag-register write or a side-effect access to a timer or the shifter. Directed cases pair each kind of clear with a pulse on the matching bit. The random phase produces such collisions freely, since pulses are drawn independently of the bus access. In each case the flag register is read on the following cycle, and the flag is expected to still be set. The registered `irq` is compared every cycle against a model that lags the flag and mask state by one edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int NFLAG = DW - 1;
    localparam int SEL_BIT = DW - 1;

    localparam logic [AW-1:0] ADR_T1_CNT_LO = 4'h4;
    localparam logic [AW-1:0] ADR_T1_CNT_HI = 4'h5;
    localparam logic [AW-1:0] ADR_T1_LAT_HI = 4'h7;
    localparam logic [AW-1:0] ADR_T2_CNT_LO = 4'h8;
    localparam logic [AW-1:0] ADR_T2_CNT_HI = 4'h9;
    localparam logic [AW-1:0] ADR_SHIFT     = 4'hA;
    localparam logic [AW-1:0] ADR_FLAG      = 4'hD;
    localparam logic [AW-1:0] ADR_MASK      = 4'hE;

    localparam int BIT_SHIFT = 2;
    localparam int BIT_T2    = 5;
    localparam int BIT_T1    = 6;

    typedef struct packed {
        logic [NFLAG-1:0] flag;
        logic [NFLAG-1:0] mask;
        logic             irq;
    } irqc_state_t;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
(
    input  logic [AW-1:0]    reg_sel,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    output logic [NFLAG-1:0] clr_vec,
    output logic             mask_wr,
    output logic             mask_set,
    output logic [NFLAG-1:0] mask_bits
);
    logic t1_hit;
    logic t2_hit;
    logic sh_hit;

    always_comb begin
        t1_hit = (rd_en && reg_sel == ADR_T1_CNT_LO)
              || (wr_en && (reg_sel == ADR_T1_CNT_HI || reg_sel == ADR_T1_LAT_HI));
        t2_hit = (rd_en && reg_sel == ADR_T2_CNT_LO)
              || (wr_en && reg_sel == ADR_T2_CNT_HI);
        sh_hit = rd_en && reg_sel == ADR_SHIFT;

        clr_vec = '0;
        if (wr_en && reg_sel == ADR_FLAG) begin
            clr_vec = wr_data[NFLAG-1:0];
        end
        if (t1_hit) clr_vec[BIT_T1]    = 1'b1;
        if (t2_hit) clr_vec[BIT_T2]    = 1'b1;
        if (sh_hit) clr_vec[BIT_SHIFT] = 1'b1;

        mask_wr   = wr_en && reg_sel == ADR_MASK;
        mask_set  = wr_data[SEL_BIT];
        mask_bits = wr_data[NFLAG-1:0];
    end
endmodule

// File: rtl/irqc_core.sv
module irqc_core
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] evt_set,
    input  logic [NFLAG-1:0] clr_vec,
    input  logic             mask_wr,
    input  logic             mask_set,
    input  logic [NFLAG-1:0] mask_bits,
    output logic [NFLAG-1:0] flag_q,
    output logic [NFLAG-1:0] mask_q,
    output logic             irq_q
);
    irqc_state_t st_d;
    irqc_state_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.irq  = |(st_q.flag & st_q.mask);
        st_d.flag = (st_q.flag & ~clr_vec) | evt_set;
        if (mask_wr) begin
            st_d.mask = mask_set ? (st_q.mask | mask_bits)
                                 : (st_q.mask & ~mask_bits);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_q = st_q.flag;
    assign mask_q = st_q.mask;
    assign irq_q  = st_q.irq;

    // R1
    irq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_q == $past(|(flag_q & mask_q))));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> ((flag_q & $past(evt_set)) == $past(evt_set)));

    // R5
    clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~evt_set)) |=> ((flag_q & $past(clr_vec & ~evt_set)) == 7'd0));

    // R4
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && mask_set) |=> ((mask_q & $past(mask_bits)) == $past(mask_bits)));

    // R4
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !mask_set) |=> ((mask_q & $past(mask_bits)) == 7'd0));

    // R11
    no_spurious_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(evt_set)) == 7'd0));
endmodule

// File: rtl/irqc_readback.sv
module irqc_readback
    import irqc_pkg::*;
(
    input  logic [AW-1:0]    reg_sel,
    input  logic [NFLAG-1:0] flag,
    input  logic [NFLAG-1:0] mask,
    output logic [DW-1:0]    rd_data
);
    always_comb begin
        unique case (reg_sel)
            ADR_FLAG: rd_data = {|(flag & mask), flag};
            ADR_MASK: rd_data = {1'b1, mask};
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    reg_sel,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data,
    input  logic [NFLAG-1:0] evt_set,
    output logic             irq
);
    logic [NFLAG-1:0] clr_vec;
    logic             mask_wr;
    logic             mask_set;
    logic [NFLAG-1:0] mask_bits;
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] mask_q;

    irqc_decode u_decode (
        .reg_sel   (reg_sel),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .clr_vec   (clr_vec),
        .mask_wr   (mask_wr),
        .mask_set  (mask_set),
        .mask_bits (mask_bits)
    );

    irqc_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_set   (evt_set),
        .clr_vec   (clr_vec),
        .mask_wr   (mask_wr),
        .mask_set  (mask_set),
        .mask_bits (mask_bits),
        .flag_q    (flag_q),
        .mask_q    (mask_q),
        .irq_q     (irq)
    );

    irqc_readback u_readback (
        .reg_sel (reg_sel),
        .flag    (flag_q),
        .mask    (mask_q),
        .rd_data (rd_data)
    );
endmodule

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
    import irqc_pkg::*;

    localparam time CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_sel = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [6:0] evt_set = '0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [6:0] m_flag = '0;
    logic [6:0] m_mask = '0;
    logic       m_irq  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_flag_ctrl u_irq_flag_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .evt_set(evt_set), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // side-effect clears, from R5..R8
    function automatic logic [6:0] exp_clr(input logic [3:0] s, input logic r,
                                           input logic w, input logic [7:0] d);
        logic [6:0] c = '0;
        if (w && s == 4'hD) c = d[6:0];
        if ((r && s == 4'h4) || (w && (s == 4'h5 || s == 4'h7))) c[6] = 1'b1;
        if ((r && s == 4'h8) || (w && s == 4'h9)) c[5] = 1'b1;
        if (r && s == 4'hA) c[2] = 1'b1;
        return c;
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] s);
        if (s == 4'hD) return {|(m_flag & m_mask), m_flag};
        if (s == 4'hE) return {1'b1, m_mask};
        return 8'h00;
    endfunction

    task automatic cyc(input logic [3:0] s, input logic r, input logic w,
                       input logic [7:0] d, input logic [6:0] e, input string tag);
        logic [6:0] c;
        reg_sel = s; rd_en = r; wr_en = w; wr_data = d; evt_set = e;
        #1;
        check(tag, rd_data, exp_read(s));
        @(posedge clk);
        c      = exp_clr(s, r, w, d);
        m_irq  = |(m_flag & m_mask);
        m_flag = (m_flag & ~c) | e;
        if (w && s == 4'hE) m_mask = d[7] ? (m_mask | d[6:0]) : (m_mask & ~d[6:0]);
        #1;
        check("R1", {7'd0, irq}, {7'd0, m_irq});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(4'h0, 1'b0, 1'b0, 8'h00, 7'h00, "R11");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] s;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #1;
        reg_sel = 4'hD; #1; check("R9", rd_data, 8'h00);
        reg_sel = 4'hE; #1; check("R9", rd_data, 8'h80);
        check("R9", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        idle(2);

        // R2 pending without enable
        cyc(4'h0, 0, 0, 8'h00, 7'h40, "R11");
        cyc(4'hD, 1, 0, 8'h00, 7'h00, "R2");
        // R4 set-mode enable, R3 readback
        cyc(4'hE, 0, 1, 8'hC0, 7'h00, "R4");
        cyc(4'hE, 1, 0, 8'h00, 7'h00, "R3");
        cyc(4'hD, 1, 0, 8'h00, 7'h00, "R2");
        idle(1);
        check("R1", {7'd0, irq}, 8'h01);
        // R6 three ways
        cyc(4'h4, 1, 0, 8'h00, 7'h00, "R6");
        cyc(4'hD, 1, 0, 8'h00, 7'h00, "R6");
        cyc(4'h0, 0, 0, 8'h00, 7'h40, "R6");
        cyc(4'h7, 0, 1, 8'h12, 7'h00, "R6");
        cyc(4'hD, 1, 0, 8'h00, 7'h00, "R6");
        cyc(4'h0, 0, 0, 8'h00, 7'h40, "R6");
        cyc(4'h5, 0, 1, 8'h34, 7'h00, "R6");
        cyc(4'hD, 1, 0, 8'h00, 7'h00, "R6");
        // R11 non-clearing timer-1 accesses
        cyc(4'h0, 0, 0, 8'h00, 7'h40, "R11");
        cyc(4'h5, 1, 0, 8'h00, 7'h00, "R11");
        cyc(4'h4, 0, 1, 8'hFF, 7'h00, "R11");
        cyc(4'hD, 1, 0, 8'h00, 7'h00, "R11");
        check("R11", rd_data, 8'hC0);
        // R7
        cyc(4'h0, 0, 0, 8'h00, 7'h20, "R7");
        cyc(4'h9, 1, 0, 8'h00, 7'h00, "R11");
        cyc(4'h8, 1, 0, 8'h00, 7'h00, "R7");
        cyc(4'hD, 1, 0, 8'h00, 7'h00, "R7");
        cyc(4'h0, 0, 0, 8'h00, 7'h20, "R7");
        cyc(4'h9, 0, 1, 8'h00, 7'h00, "R7");
        cyc(4'hD, 1, 0, 8'h00, 7'h00, "R7");
        // R8
        cyc(4'h0, 0, 0, 8'h00, 7'h04, "R8");
        cyc(4'hA, 0, 1, 8'hFF, 7'h00, "R11");
        cyc(4'hA, 1, 0, 8'h00, 7'h00, "R8");
        cyc(4'hD, 1, 0, 8'h00, 7'h00, "R8");
        // R5
        cyc(4'h0, 0, 0, 8'h00, 7'h7F, "R5");
        cyc(4'hD, 0, 1, 8'h0A, 7'h00, "R5");
        cyc(4'hD, 0, 1, 8'h80, 7'h00, "R5");
        cyc(4'hD, 1, 0, 8'h00, 7'h00, "R5");
        check("R5", rd_data, 8'hF5);
        // R4 clear mode
        cyc(4'hE, 0, 1, 8'h40, 7'h00, "R4");
        cyc(4'hE, 1, 0, 8'h00, 7'h00, "R4");
        check("R4", rd_data, 8'h80);
        // R10 collisions
        cyc(4'h4, 1, 0, 8'h00, 7'h40, "R10");
        cyc(4'hD, 0, 1, 8'h20, 7'h20, "R10");
        cyc(4'hA, 1, 0, 8'h00, 7'h04, "R10");
        cyc(4'hD, 1, 0, 8'h00, 7'h00, "R10");
        check("R10", rd_data & 8'h64, 8'h64);

        // constrained random
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            case (rv[2:0])
                3'd0: s = 4'hD;
                3'd1: s = 4'hE;
                3'd2: s = 4'h4;
                3'd3: s = 4'h8;
                3'd4: s = 4'hA;
                3'd5: s = rv[3] ? 4'h5 : 4'h9;
                default: s = rv[7:4];
            endcase
            cyc(s, rv[8], rv[9] & rv[10], 8'($urandom),
                7'($urandom & $urandom & $urandom),
                (s == 4'hD) ? "R2" : (s == 4'hE) ? "R3" : "R11");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule